// File: doc/BRIEF.md
# Receive Frame Filter with Dewhitening

This block sits behind a sync-word detector in a packet receiver. Once a start pulse marks the end of the sync pattern, it takes the received bytes one at a time. It works out how long the frame is, either from a programmed length or from the first received byte. It can reject frames by address and can undo data whitening. It forwards the accepted bytes to a receive FIFO as write strobes. The two trailing check bytes are verified against a CRC-16 computed over the forwarded bytes.

When a frame ends, the block reports the result through a ready flag and a check-passed flag. Both flags stay up until the FIFO reports that it is empty. A frame that is rejected or fails its check produces a one-cycle flush request, which tells the FIFO to throw away what was stored. The FIFO storage itself, the sync detector and the bit-level line decoding sit outside this block.

Top module: `rx_frame_filter`

## Requirements
- R1: While `rst` is high and in the cycle after it, `fifo_wr`, `fifo_flush`, `payload_ready` and `crc_ok` are 0.
- R2: With `cfg_var_len`=0 (fixed length, `cfg_len` ≥ 1), the `cfg_len` bytes following `start` are written to the FIFO in arrival order. Each write appears the cycle after its byte is taken.
- R3: With `cfg_var_len`=1, the first byte after `start` is the length L. L is itself written to the FIFO, and then the next L bytes are written. L=0 moves straight to the check bytes.
- R4: In variable mode, a length byte greater than `cfg_len` discards the frame. The length byte is not written, `fifo_flush` pulses for one cycle, and later bytes are ignored until the next `start`.
- R5: `cfg_addr_mode` 00 disables filtering. Any other value checks the first payload-region byte (the first byte in fixed mode, the byte after the length in variable mode) against `cfg_node_addr`. On a mismatch, that byte is not written, `fifo_flush` pulses, and the block waits for `start`.
- R6: `cfg_addr_mode` 10 or 11 also accepts `cfg_bcast_addr` as the address. Mode 01 accepts only `cfg_node_addr`.
- R7: With `cfg_crc_on`=1, two check bytes follow the payload, high byte first, and neither is written. The CRC is CRC-16 with polynomial 0x1021 and initial value 0x1D0F, taken MSB-first over every written byte. If the check bytes equal the bitwise inverse of that CRC, `payload_ready` and `crc_ok` rise the cycle after the low check byte.
- R8: On a check mismatch with `cfg_crc_keep`=0, `payload_ready` and `crc_ok` stay low and `fifo_flush` pulses for exactly one cycle. `fifo_flush` is never high together with `fifo_wr`.
- R9: On a check mismatch with `cfg_crc_keep`=1, `payload_ready` rises, `crc_ok` stays low and no flush is issued.
- R10: With `cfg_crc_on`=0, `payload_ready` rises the cycle after the last payload byte, `crc_ok` stays low, and no check bytes are expected.
- R11: With `cfg_dcfree`=10, every byte after `start` (length, address, payload, check bytes) is XORed with an 8-bit mask from a 9-bit LFSR. The LFSR is seeded to 0x1FF at `start`. Each mask bit i (bit 0 first) is the state's bit 0. The state then shifts right, with bit 8 taking bit 0 XOR bit 5. The LFSR advances 8 steps per taken byte. Any other `cfg_dcfree` value passes bytes through unchanged.
- R12: `payload_ready` and `crc_ok` fall when `fifo_empty` is 1 in a cycle where they are not being set. Otherwise they hold their value.
- R13: Bytes presented while `byte_vld`=0, or while no frame is open, cause no write and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: sync found, frame begins |
| byte_vld | input | 1 | `byte_in` holds a received byte this cycle |
| byte_in | input | DW | Received byte as on the line |
| cfg_var_len | input | 1 | 0 fixed length, 1 length taken from first byte |
| cfg_len | input | DW | Fixed length, or maximum length in variable mode |
| cfg_addr_mode | input | 2 | 00 off, 01 node only, 1x node or broadcast |
| cfg_node_addr | input | DW | Node address |
| cfg_bcast_addr | input | DW | Broadcast address |
| cfg_dcfree | input | 2 | 10 enables dewhitening |
| cfg_crc_on | input | 1 | Check bytes present and verified |
| cfg_crc_keep | input | 1 | Keep FIFO contents and raise ready on check mismatch |
| fifo_empty | input | 1 | FIFO reports empty; clears result flags |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | DW | FIFO write data |
| fifo_flush | output | 1 | One-cycle request to clear the FIFO |
| payload_ready | output | 1 | Frame complete flag |
| crc_ok | output | 1 | Check passed flag |

## Verification
The frame path is exercised with a fixed-length clear-text frame, which shows that bytes pass through in order and that the CRC covers only the written bytes. A variable-length, whitened, node-addressed frame shows that the mask sequence lines up from the length byte through to the check bytes. Further patterns cover an oversize length byte, a wrong address, and the broadcast address under both filter modes; these separate the two rejection paths from acceptance. Check-byte corruption with and without the keep option, plus a frame without a check, separate the three ways a frame can end. A gap in `byte_vld` inside a frame and bytes sent while idle show that only taken bytes count.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LEN,
    S_ADDR,
    S_PAY,
    S_CRC_HI,
    S_CRC_LO
  } rxf_state_t;

  localparam logic [1:0] ADDR_OFF   = 2'b00;
  localparam logic [1:0] DCF_WHITEN = 2'b10;
endpackage

// File: rtl/rxf_dewhiten.sv
module rxf_dewhiten #(
  parameter int LW  = 9,
  parameter int TAP = 5,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  output logic [DW-1:0] mask
);
  localparam logic [LW-1:0] SEED = {LW{1'b1}};

  logic [LW-1:0] st_q;
  logic [LW-1:0] st_nxt;

  always_comb begin
    logic [LW-1:0] s;
    logic          fb;
    s = st_q;
    for (int i = 0; i < DW; i++) begin
      mask[i] = s[0];
      fb      = s[0] ^ s[TAP];
      s       = {fb, s[LW-1:1]};
    end
    st_nxt = s;
  end

  always_ff @(posedge clk) begin
    if (rst || load) st_q <= SEED;
    else if (adv)    st_q <= st_nxt;
  end
endmodule

// File: rtl/rxf_crc16.sv
module rxf_crc16 #(
  parameter int          CW   = 16,
  parameter int          DW   = 8,
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'h1D0F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [CW-1:0] crc
);
  logic [CW-1:0] crc_nxt;

  always_comb begin
    logic [CW-1:0] c;
    logic          fb;
    c = crc;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = c[CW-1] ^ din[i];
      c  = {c[CW-2:0], 1'b0};
      if (fb) c = c ^ POLY[CW-1:0];
    end
    crc_nxt = c;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= INIT[CW-1:0];
    else if (en)    crc <= crc_nxt;
  end
endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match #(
  parameter int DW = 8
) (
  input  logic [1:0]    mode,
  input  logic [DW-1:0] node,
  input  logic [DW-1:0] bcast,
  input  logic [DW-1:0] addr,
  output logic          hit
);
  import rxf_pkg::*;

  always_comb begin
    hit = (mode == ADDR_OFF) || (addr == node) || (mode[1] && (addr == bcast));
  end
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter #(
  parameter int DW  = 8,
  parameter int CW  = 16,
  parameter int LW  = 9,
  parameter int TAP = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_in,
  input  logic          cfg_var_len,
  input  logic [DW-1:0] cfg_len,
  input  logic [1:0]    cfg_addr_mode,
  input  logic [DW-1:0] cfg_node_addr,
  input  logic [DW-1:0] cfg_bcast_addr,
  input  logic [1:0]    cfg_dcfree,
  input  logic          cfg_crc_on,
  input  logic          cfg_crc_keep,
  input  logic          fifo_empty,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_wdata,
  output logic          fifo_flush,
  output logic          payload_ready,
  output logic          crc_ok
);
  import rxf_pkg::*;

  localparam logic [DW-1:0] ONE = DW'(1);

  rxf_state_t    state_q, state_d;
  logic [DW-1:0] left_q, left_d;
  logic [DW-1:0] chk_hi_q;
  logic [DW-1:0] mask, cur;
  logic [CW-1:0] crc;
  logic          dw_on, addr_on, take, addr_hit;
  logic          wr_d, flush_d, crc_en, set_rdy, set_ok, hi_ld;
  rxf_state_t    tail_st;

  rxf_dewhiten #(.LW(LW), .TAP(TAP), .DW(DW)) i_dewhiten (
    .clk (clk),
    .rst (rst),
    .load(start),
    .adv (take),
    .mask(mask)
  );

  rxf_crc16 #(.CW(CW), .DW(DW)) i_crc (
    .clk(clk),
    .rst(rst),
    .clr(start),
    .en (crc_en),
    .din(cur),
    .crc(crc)
  );

  rxf_addr_match #(.DW(DW)) i_addr (
    .mode (cfg_addr_mode),
    .node (cfg_node_addr),
    .bcast(cfg_bcast_addr),
    .addr (cur),
    .hit  (addr_hit)
  );

  assign dw_on   = (cfg_dcfree == DCF_WHITEN);
  assign addr_on = (cfg_addr_mode != ADDR_OFF);
  assign cur     = byte_in ^ (dw_on ? mask : '0);
  assign take    = byte_vld && !start && (state_q != S_IDLE);
  assign tail_st = cfg_crc_on ? S_CRC_HI : S_IDLE;

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    wr_d    = 1'b0;
    flush_d = 1'b0;
    crc_en  = 1'b0;
    set_rdy = 1'b0;
    set_ok  = 1'b0;
    hi_ld   = 1'b0;
    if (start) begin
      left_d  = cfg_len;
      state_d = cfg_var_len ? S_LEN : (addr_on ? S_ADDR : S_PAY);
    end else if (take) begin
      unique case (state_q)
        S_LEN: begin
          if (cur > cfg_len) begin
            flush_d = 1'b1;
            state_d = S_IDLE;
          end else begin
            wr_d   = 1'b1;
            crc_en = 1'b1;
            left_d = cur;
            if (cur == '0) begin
              state_d = tail_st;
              set_rdy = !cfg_crc_on;
            end else begin
              state_d = addr_on ? S_ADDR : S_PAY;
            end
          end
        end
        S_ADDR, S_PAY: begin
          if (state_q == S_ADDR && !addr_hit) begin
            flush_d = 1'b1;
            state_d = S_IDLE;
          end else begin
            wr_d   = 1'b1;
            crc_en = 1'b1;
            left_d = left_q - ONE;
            if (left_q == ONE) begin
              state_d = tail_st;
              set_rdy = !cfg_crc_on;
            end else begin
              state_d = S_PAY;
            end
          end
        end
        S_CRC_HI: begin
          hi_ld   = 1'b1;
          state_d = S_CRC_LO;
        end
        S_CRC_LO: begin
          state_d = S_IDLE;
          if ({chk_hi_q, cur} == ~crc) begin
            set_rdy = 1'b1;
            set_ok  = 1'b1;
          end else if (cfg_crc_keep) begin
            set_rdy = 1'b1;
          end else begin
            flush_d = 1'b1;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= S_IDLE;
      left_q        <= '0;
      chk_hi_q      <= '0;
      fifo_wr       <= 1'b0;
      fifo_wdata    <= '0;
      fifo_flush    <= 1'b0;
      payload_ready <= 1'b0;
      crc_ok        <= 1'b0;
    end else begin
      state_q    <= state_d;
      left_q     <= left_d;
      fifo_wr    <= wr_d;
      fifo_flush <= flush_d;
      if (hi_ld) chk_hi_q   <= cur;
      if (wr_d)  fifo_wdata <= cur;
      if (set_rdy)         payload_ready <= 1'b1;
      else if (fifo_empty) payload_ready <= 1'b0;
      if (set_ok)                    crc_ok <= 1'b1;
      else if (set_rdy || fifo_empty) crc_ok <= 1'b0;
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          byte_vld,
  input logic [DW-1:0] byte_in,
  input logic [1:0]    cfg_dcfree,
  input logic          fifo_empty,
  input logic          fifo_wr,
  input logic [DW-1:0] fifo_wdata,
  input logic          fifo_flush,
  input logic          payload_ready,
  input logic          crc_ok
);
  p_wr_needs_byte_r13: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> $past(byte_vld));

  p_no_wr_with_flush_r8: assert property (@(posedge clk) disable iff (rst)
    !(fifo_wr && fifo_flush));

  p_flush_single_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |=> !fifo_flush);

  p_ready_rise_no_flush_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(payload_ready) |-> !fifo_flush);

  p_ok_implies_ready_r7: assert property (@(posedge clk) disable iff (rst)
    crc_ok |-> payload_ready);

  p_ready_falls_on_empty_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(payload_ready) |-> $past(fifo_empty));

  p_clear_pass_r11: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr && ($past(cfg_dcfree) != 2'b10)) |-> (fifo_wdata == $past(byte_in)));
endmodule

bind rx_frame_filter rxf_checker #(.DW(DW)) i_rxf_checker (
  .clk          (clk),
  .rst          (rst),
  .byte_vld     (byte_vld),
  .byte_in      (byte_in),
  .cfg_dcfree   (cfg_dcfree),
  .fifo_empty   (fifo_empty),
  .fifo_wr      (fifo_wr),
  .fifo_wdata   (fifo_wdata),
  .fifo_flush   (fifo_flush),
  .payload_ready(payload_ready),
  .crc_ok       (crc_ok)
);

// File: tb/test_rx_frame_filter.sv
module test_rx_frame_filter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, start, byte_vld;
  logic [7:0] byte_in, cfg_len, cfg_node_addr, cfg_bcast_addr;
  logic       cfg_var_len, cfg_crc_on, cfg_crc_keep, fifo_empty;
  logic [1:0] cfg_addr_mode, cfg_dcfree;
  logic       fifo_wr, fifo_flush, payload_ready, crc_ok;
  logic [7:0] fifo_wdata;

  int   n_chk = 0;
  int   n_bad = 0;
  logic [8:0]  tb_lf;
  logic [15:0] tb_crc;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_filter i_rx_frame_filter (
    .clk(clk), .rst(rst), .start(start), .byte_vld(byte_vld), .byte_in(byte_in),
    .cfg_var_len(cfg_var_len), .cfg_len(cfg_len), .cfg_addr_mode(cfg_addr_mode),
    .cfg_node_addr(cfg_node_addr), .cfg_bcast_addr(cfg_bcast_addr),
    .cfg_dcfree(cfg_dcfree), .cfg_crc_on(cfg_crc_on), .cfg_crc_keep(cfg_crc_keep),
    .fifo_empty(fifo_empty), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .fifo_flush(fifo_flush), .payload_ready(payload_ready), .crc_ok(crc_ok)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic next_mask(output logic [7:0] m);
    for (int i = 0; i < 8; i++) begin
      m[i]  = tb_lf[0];
      tb_lf = {tb_lf[0] ^ tb_lf[5], tb_lf[8:1]};
    end
  endtask

  task automatic crc_add(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb     = tb_crc[15] ^ d[i];
      tb_crc = {tb_crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
  endtask

  task automatic begin_frame();
    start = 1'b1;
    cyc();
    start  = 1'b0;
    tb_lf  = 9'h1FF;
    tb_crc = 16'h1D0F;
    chk("R13 no write on start", {15'd0, fifo_wr}, 16'd0);
  endtask

  task automatic send(input logic [7:0] clr, input logic exp_wr, input string tag);
    logic [7:0] m;
    next_mask(m);
    byte_in  = clr ^ ((cfg_dcfree == 2'b10) ? m : 8'h00);
    byte_vld = 1'b1;
    cyc();
    byte_vld = 1'b0;
    chk({tag, " wr"}, {15'd0, fifo_wr}, {15'd0, exp_wr});
    if (exp_wr) begin
      chk({tag, " data"}, {8'd0, fifo_wdata}, {8'd0, clr});
      crc_add(clr);
    end
  endtask

  task automatic send_chk(input logic corrupt, input logic e_rdy, input logic e_ok,
                          input logic e_fl, input string tag);
    logic [15:0] v;
    v = ~tb_crc ^ (corrupt ? 16'h0004 : 16'h0000);
    send(v[15:8], 1'b0, {tag, " chk hi"});
    send(v[7:0],  1'b0, {tag, " chk lo"});
    chk({tag, " ready"}, {15'd0, payload_ready}, {15'd0, e_rdy});
    chk({tag, " ok"},    {15'd0, crc_ok},        {15'd0, e_ok});
    chk({tag, " flush"}, {15'd0, fifo_flush},    {15'd0, e_fl});
    cyc();
    chk({tag, " flush one cycle"}, {15'd0, fifo_flush}, 16'd0);
  endtask

  task automatic drain();
    fifo_empty = 1'b1;
    cyc();
    fifo_empty = 1'b0;
    chk("R12 ready cleared by empty", {15'd0, payload_ready}, 16'd0);
    chk("R12 ok cleared by empty",    {15'd0, crc_ok},        16'd0);
  endtask

  task automatic cfg(input logic vl, input logic [7:0] len, input logic [1:0] am,
                     input logic [1:0] dc, input logic con, input logic keep);
    cfg_var_len = vl; cfg_len = len; cfg_addr_mode = am;
    cfg_dcfree = dc; cfg_crc_on = con; cfg_crc_keep = keep;
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; byte_vld = 1'b0; byte_in = 8'h00; fifo_empty = 1'b0;
    cfg(1'b0, 8'd3, 2'b00, 2'b00, 1'b1, 1'b0);
    cfg_node_addr = 8'h5A; cfg_bcast_addr = 8'hFF;
    repeat (3) cyc();
    chk("R1 wr in reset", {15'd0, fifo_wr}, 16'd0);
    chk("R1 ready in reset", {15'd0, payload_ready}, 16'd0);
    rst = 1'b0;
    cyc();
    chk("R1 flush after reset", {15'd0, fifo_flush}, 16'd0);
    chk("R1 ok after reset", {15'd0, crc_ok}, 16'd0);
  endtask

  task automatic t_fixed_plain();
    cfg(1'b0, 8'd3, 2'b00, 2'b00, 1'b1, 1'b0);
    send(8'h77, 1'b0, "R13 idle byte ignored");
    begin_frame();
    send(8'hA1, 1'b1, "R2 byte0");
    cyc();
    chk("R13 vld low no write", {15'd0, fifo_wr}, 16'd0);
    send(8'hB2, 1'b1, "R2 byte1");
    send(8'hC3, 1'b1, "R2 byte2");
    send_chk(1'b0, 1'b1, 1'b1, 1'b0, "R7 fixed pass");
    cyc();
    chk("R12 ready holds", {15'd0, payload_ready}, 16'd1);
    chk("R12 ok holds", {15'd0, crc_ok}, 16'd1);
    drain();
  endtask

  task automatic t_var_whiten();
    cfg(1'b1, 8'd8, 2'b01, 2'b10, 1'b1, 1'b0);
    begin_frame();
    send(8'h03, 1'b1, "R3 R11 length");
    send(8'h5A, 1'b1, "R5 R11 node addr");
    send(8'h11, 1'b1, "R11 pay0");
    send(8'h22, 1'b1, "R11 pay1");
    send_chk(1'b0, 1'b1, 1'b1, 1'b0, "R11 whitened pass");
    drain();
    cfg(1'b1, 8'd8, 2'b00, 2'b00, 1'b1, 1'b0);
    begin_frame();
    send(8'h00, 1'b1, "R3 zero length");
    send_chk(1'b0, 1'b1, 1'b1, 1'b0, "R3 zero length pass");
    drain();
  endtask

  task automatic t_len_reject();
    cfg(1'b1, 8'd4, 2'b00, 2'b00, 1'b1, 1'b0);
    begin_frame();
    send(8'h05, 1'b0, "R4 oversize length");
    chk("R4 flush", {15'd0, fifo_flush}, 16'd1);
    send(8'h33, 1'b0, "R4 later byte ignored");
    chk("R4 single flush", {15'd0, fifo_flush}, 16'd0);
    begin_frame();
    send(8'h04, 1'b1, "R4 length at max");
  endtask

  task automatic t_addr();
    cfg(1'b0, 8'd2, 2'b01, 2'b00, 1'b1, 1'b0);
    begin_frame();
    send(8'h5B, 1'b0, "R5 wrong addr");
    chk("R5 flush", {15'd0, fifo_flush}, 16'd1);
    send(8'h10, 1'b0, "R5 dropped byte");
    begin_frame();
    send(8'hFF, 1'b0, "R6 bcast in node-only");
    chk("R6 flush", {15'd0, fifo_flush}, 16'd1);
    cfg(1'b0, 8'd2, 2'b10, 2'b00, 1'b1, 1'b0);
    begin_frame();
    send(8'hFF, 1'b1, "R6 bcast accepted");
    send(8'h10, 1'b1, "R6 pay");
    send_chk(1'b0, 1'b1, 1'b1, 1'b0, "R6 bcast pass");
    drain();
  endtask

  task automatic t_crc_fail();
    cfg(1'b0, 8'd2, 2'b00, 2'b00, 1'b1, 1'b0);
    begin_frame();
    send(8'h01, 1'b1, "R8 pay0");
    send(8'h02, 1'b1, "R8 pay1");
    send_chk(1'b1, 1'b0, 1'b0, 1'b1, "R8 mismatch");
    cfg(1'b0, 8'd2, 2'b00, 2'b00, 1'b1, 1'b1);
    begin_frame();
    send(8'h01, 1'b1, "R9 pay0");
    send(8'h02, 1'b1, "R9 pay1");
    send_chk(1'b1, 1'b1, 1'b0, 1'b0, "R9 keep on mismatch");
    drain();
  endtask

  task automatic t_no_crc();
    cfg(1'b0, 8'd2, 2'b00, 2'b00, 1'b0, 1'b0);
    begin_frame();
    send(8'h44, 1'b1, "R10 pay0");
    chk("R10 not ready early", {15'd0, payload_ready}, 16'd0);
    send(8'h55, 1'b1, "R10 pay1");
    chk("R10 ready", {15'd0, payload_ready}, 16'd1);
    chk("R10 ok low", {15'd0, crc_ok}, 16'd0);
    send(8'h66, 1'b0, "R10 no check bytes");
    drain();
  endtask

  initial begin
    t_reset();
    t_fixed_plain();
    t_var_whiten();
    t_len_reject();
    t_addr();
    t_crc_fail();
    t_no_crc();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule